// File: doc/BRIEF.md
# Staged-Configuration Crosspoint Router

This block routes sixteen single-bit data lanes to sixteen output lanes. Every output picks exactly one input, and any input may feed any number of outputs at once, so a single source can be broadcast to all outputs. Routing moves through two stages. A bank of per-output pending selections is written one output at a time through an address interface. An active routing latch drives the output multiplexers.

A write places an input number and an enable flag into the pending entry of one output. The write happens on each clock edge at which the active-low load strobe is low. An active-low configure strobe copies the whole pending bank into the active latch in one step, so any group of outputs switches together. While the configure strobe stays low the latch follows the bank, and a write reaches the outputs after that same edge. Loading with the configure strobe high leaves the live routing alone. A disabled output drives 0.

Top module: `xbar_cfg_switch`

## Requirements
- R1: After reset every pending and active entry is cleared: each output selects input 0 and is disabled, so every output reads 0 whatever the inputs. A configure pulse with nothing loaded keeps all outputs at 0.
- R2: A write with the configure strobe high does not change any output.
- R3: On a clock edge with `load_n` low, the pending entry addressed by `out_addr` (bit 3 most significant) takes `in_addr` (bit 3 most significant) as its input number and `out_en` as its enable.
- R4: On a clock edge with `cfg_n` low, all sixteen active entries take their pending values in parallel. The outputs follow right after that edge.
- R5: When `load_n` and `cfg_n` are both low at the same edge, the value written at that edge reaches the output right after that edge. This makes the latch transparent while `cfg_n` stays low.
- R6: An enabled output equals the input its active entry selects. Several outputs may select the same input.
- R7: A disabled output drives 0 whatever input it selects.
- R8: Writes to different outputs accumulate in the bank. A later write to the same output replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| din | input | 16 | Data input lanes |
| dout | output | 16 | Data output lanes |
| load_n | input | 1 | Active-low write strobe for the pending bank |
| cfg_n | input | 1 | Active-low configure strobe; held low makes the latch transparent |
| out_addr | input | 4 | Number of the output whose pending entry is written |
| in_addr | input | 4 | Input number written into the addressed entry |
| out_en | input | 1 | Enable flag written with the selection |

## Verification
A write and a configure copy can land on the same clock edge. The copy must then take the value being written at that edge, not the stale one. The bench provokes this by holding `cfg_n` low while strobing writes, including two writes in a row to one output. After each edge it compares every output against a model in which the pending update is applied before the copy. Plain staged loads, one-cycle configure pulses and broadcast sweeps over all sixteen inputs check the non-overlapping cases for contrast.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int LANES = 16;
  localparam int SEL_W = $clog2(LANES);

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } route_t;

  localparam int ROUTE_W = $bits(route_t);
endpackage

// File: rtl/xbar_rst_sync.sv
module xbar_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/xbar_pending_bank.sv
module xbar_pending_bank
  import xbar_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_n,
  input  logic [SEL_W-1:0]        wr_addr,
  input  route_t                  wr_route,
  output route_t [N_LANES-1:0]    pend_d,
  output route_t [N_LANES-1:0]    pend_q
);
  for (genvar o = 0; o < N_LANES; o++) begin : g_entry
    logic hit;
    assign hit = !wr_n && (wr_addr == SEL_W'(o));

    always_comb begin
      pend_d[o] = pend_q[o];
      if (hit) pend_d[o] = wr_route;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pend_q[o] <= '0;
      else if (hit) pend_q[o] <= pend_d[o];
    end
  end
endmodule

// File: rtl/xbar_active_latch.sv
module xbar_active_latch
  import xbar_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_n,
  input  route_t [N_LANES-1:0]    pend_d,
  output route_t [N_LANES-1:0]    act_q
);
  logic                 copy_en;
  route_t [N_LANES-1:0] act_d;

  always_comb begin
    copy_en = !cfg_n;
    act_d   = copy_en ? pend_d : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       act_q <= '0;
    else if (copy_en) act_q <= act_d;
  end
endmodule

// File: rtl/xbar_route_mux.sv
module xbar_route_mux
  import xbar_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic [N_LANES-1:0]      din,
  input  route_t [N_LANES-1:0]    act_q,
  output logic [N_LANES-1:0]      dout
);
  for (genvar o = 0; o < N_LANES; o++) begin : g_out
    assign dout[o] = act_q[o].en & din[act_q[o].sel];
  end
endmodule

// File: rtl/xbar_cfg_switch.sv
module xbar_cfg_switch
  import xbar_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LANES-1:0]  din,
  output logic [N_LANES-1:0]  dout,
  input  logic                load_n,
  input  logic                cfg_n,
  input  logic [SEL_W-1:0]    out_addr,
  input  logic [SEL_W-1:0]    in_addr,
  input  logic                out_en
);
  logic                 rst_sync_n;
  route_t               wr_route;
  route_t [N_LANES-1:0] pend_d;
  route_t [N_LANES-1:0] pend_q;
  route_t [N_LANES-1:0] act_q;

  assign wr_route = '{en: out_en, sel: in_addr};

  xbar_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  xbar_pending_bank #(.N_LANES(N_LANES)) u_bank (
    .clk(clk), .rst_n(rst_sync_n), .wr_n(load_n), .wr_addr(out_addr),
    .wr_route(wr_route), .pend_d(pend_d), .pend_q(pend_q)
  );

  xbar_active_latch #(.N_LANES(N_LANES)) u_act (
    .clk(clk), .rst_n(rst_sync_n), .cfg_n(cfg_n),
    .pend_d(pend_d), .act_q(act_q)
  );

  xbar_route_mux #(.N_LANES(N_LANES)) u_mux (
    .din(din), .act_q(act_q), .dout(dout)
  );
endmodule

// File: rtl/xbar_cfg_switch_chk.sv
module xbar_cfg_switch_chk
  import xbar_pkg::*;
#(
  parameter int N_LANES = LANES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load_n,
  input  logic                         cfg_n,
  input  logic [SEL_W-1:0]             out_addr,
  input  logic [SEL_W-1:0]             in_addr,
  input  logic                         out_en,
  input  logic [N_LANES-1:0]           din,
  input  logic [N_LANES-1:0]           dout,
  input  logic [N_LANES*ROUTE_W-1:0]   pend_q,
  input  logic [N_LANES*ROUTE_W-1:0]   act_q
);
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (act_q == '0 && pend_q == '0));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_n |=> $stable(act_q));

  a_r3_write: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> pend_q[$past(out_addr)*ROUTE_W +: ROUTE_W] == {$past(out_en), $past(in_addr)});

  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_n |=> act_q == pend_q);

  for (genvar o = 0; o < N_LANES; o++) begin : g_lane
    a_r6_route: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[o*ROUTE_W + SEL_W] |-> dout[o] == din[act_q[o*ROUTE_W +: SEL_W]]);

    a_r7_off: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q[o*ROUTE_W + SEL_W] |-> !dout[o]);
  end
endmodule

bind xbar_cfg_switch xbar_cfg_switch_chk #(.N_LANES(N_LANES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .load_n(load_n), .cfg_n(cfg_n),
  .out_addr(out_addr), .in_addr(in_addr), .out_en(out_en),
  .din(din), .dout(dout), .pend_q(pend_q), .act_q(act_q)
);

// File: tb/xbar_cfg_switch_test.sv
module xbar_cfg_switch_test;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] din;
  logic [N-1:0] dout;
  logic         load_n, cfg_n, out_en;
  logic [3:0]   out_addr, in_addr;

  int checks = 0;
  int errors = 0;

  logic       m_pen [N];
  logic [3:0] m_psel[N];
  logic       m_aen [N];
  logic [3:0] m_asel[N];

  always #10 clk = ~clk;

  xbar_cfg_switch uut (
    .clk(clk), .rst_n(rst_n), .din(din), .dout(dout), .load_n(load_n),
    .cfg_n(cfg_n), .out_addr(out_addr), .in_addr(in_addr), .out_en(out_en)
  );

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // One clock edge: drive at negedge, update model at posedge, return at next negedge.
  task automatic step(input logic ld, input logic cf, input int oa, input int ia, input logic en);
    load_n = ld; cfg_n = cf; out_addr = 4'(oa); in_addr = 4'(ia); out_en = en;
    @(posedge clk);
    if (!ld) begin m_pen[oa] = en; m_psel[oa] = 4'(ia); end
    if (!cf) for (int o = 0; o < N; o++) begin m_aen[o] = m_pen[o]; m_asel[o] = m_psel[o]; end
    @(negedge clk);
    load_n = 1'b1;
  endtask

  task automatic check_routes(input string req);
    logic [N-1:0] pats[18];
    for (int i = 0; i < N; i++) pats[i] = N'(1) << i;
    pats[16] = 16'hA5C3;
    pats[17] = 16'hFFFF;
    for (int p = 0; p < 18; p++) begin
      din = pats[p];
      #1;
      for (int o = 0; o < N; o++) begin
        logic exp;
        exp = m_aen[o] & pats[p][m_asel[o]];
        checks++;
        if (dout[o] !== exp) begin
          errors++;
          $display("FAIL %s out %0d din %h: got %b expected %b", req, o, pats[p], dout[o], exp);
        end
      end
    end
  endtask

  initial begin
    for (int o = 0; o < N; o++) begin m_pen[o] = 0; m_psel[o] = 0; m_aen[o] = 0; m_asel[o] = 0; end
    rst_n = 1'b0; load_n = 1'b1; cfg_n = 1'b1; out_addr = '0; in_addr = '0; out_en = 1'b0; din = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset clears everything
    check_routes("R1");
    step(1'b1, 1'b0, 0, 0, 1'b0);
    check_routes("R1");

    // R2/R3/R4/R6: staged permutation, applied by one pulse
    for (int o = 0; o < N; o++) begin
      step(1'b0, 1'b1, o, (o*5+3) % N, 1'b1);
      if (o % 5 == 0) check_routes("R2");
    end
    check_routes("R2");
    step(1'b1, 1'b0, 0, 0, 1'b0);
    check_routes("R4");

    // R6: broadcast sweep over every input
    for (int i = 0; i < N; i++) begin
      for (int o = 0; o < N; o++) step(1'b0, 1'b1, o, i, 1'b1);
      check_routes("R2");
      step(1'b1, 1'b0, 0, 0, 1'b0);
      check_routes("R6");
    end

    // R7: disable odd outputs
    for (int o = 1; o < N; o += 2) step(1'b0, 1'b1, o, 15 - o, 1'b0);
    step(1'b1, 1'b0, 0, 0, 1'b0);
    check_routes("R7");

    // R5: transparent while configure held low, same-edge write
    step(1'b0, 1'b0, 3, 9, 1'b1);
    check_routes("R5");
    step(1'b0, 1'b0, 12, 0, 1'b1);
    check_routes("R5");

    // R8: accumulate, then overwrite same output back to back
    step(1'b0, 1'b1, 5, 2, 1'b1);
    step(1'b0, 1'b1, 6, 4, 1'b1);
    step(1'b0, 1'b1, 5, 11, 1'b1);
    check_routes("R2");
    step(1'b1, 1'b0, 0, 0, 1'b0);
    check_routes("R8");
    step(1'b0, 1'b0, 7, 1, 1'b1);
    step(1'b0, 1'b0, 7, 14, 1'b0);
    check_routes("R8");
    step(1'b0, 1'b0, 7, 13, 1'b1);
    check_routes("R5");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule